// File: doc/BRIEF.md
# Tri-State Phase Detector with Idle-Gated Power-Down

This block compares a divided reference clock with a divided VCO clock and produces two pump requests for an external charge pump. The reference request (up) means the VCO side lags. The VCO request (down) means it leads. Both inputs are level signals that are already synchronous to a fast sampling clock `clk`. Each rising edge is caught by one register stage. The two request flags form a classic three-state detector: up only, down only, or idle. A polarity input can exchange the two requests, so that loops with an inverting VCO gain can be served.

The block also has a lock indicator. It measures every pump pulse in sampling-clock cycles against a programmable width. Lock is declared after a run of clean reference periods. It is withdrawn at once when one pulse is too wide. While locked, the indicator drops low only for the cycles in which a pump request is active.

A power-down request on an active-low input does not act at once. The block waits until both requests are idle, so that no half-finished correction pulse is cut short. After that it holds both requests idle and ignores edges. When the input returns high, the flags and lock status start clear, and detection resumes at the next edge. A monitor output shows one of the two divided clocks, chosen by a select input.

Top module: `pfd_gated_pd`

## Requirements
- R1: While reset is asserted and right after it, both pump outputs and the lock output are 0.
- R2: With `pol_normal_i` = 1, a rising edge on `ref_in` sampled at clock edge t sets `pump_up_o` from edge t. A rising edge on `vco_in` sets `pump_dn_o` in the same way. A set flag stays set until the opposite edge arrives.
- R3: When both flags are set at one clock edge, both are clear from the following edge. The width of a request therefore tracks the phase gap between the two inputs.
- R4: With `pol_normal_i` = 0, the block drives the reference-side request on `pump_dn_o` and the VCO-side request on `pump_up_o`.
- R5: When `pwr_on_i` is 0, power-down starts only at an edge where neither flag is set. Until then, a pending request keeps running. Once power-down has started, both pump outputs and `lock_o` stay 0 and input edges are ignored.
- R6: When `pwr_on_i` returns to 1, the block wakes with both flags and lock clear. The first rising edge after wake-up sets its flag again.
- R7: A pulse counts as narrow when it lasts at most `pulse_limit_i` cycles. Lock is declared at the `LOCK_PERIODS`-th reference rising edge counted since the last wide pulse, reset or wake-up.
- R8: A pump pulse that lasts more than `pulse_limit_i` consecutive cycles clears the lock state on the next edge. The period count starts again from zero.
- R9: `lock_o` equals the lock state with the cycles of any active pump request masked out. While locked, it shows a low pulse exactly as long as each pump pulse.
- R10: `mon_o` follows `ref_in` when `mon_sel_i` = 0 and `vco_in` when `mon_sel_i` = 1, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference clock, synchronous level |
| vco_in | input | 1 | Divided VCO clock, synchronous level |
| pol_normal_i | input | 1 | 1: normal request sense, 0: requests exchanged |
| pwr_on_i | input | 1 | 1: run, 0: request power-down once idle |
| pulse_limit_i | input | PULSE_W | Widest pump pulse, in cycles, that still counts as locked |
| mon_sel_i | input | 1 | Monitor source: 0 reference, 1 VCO |
| pump_up_o | output | 1 | Up pump request |
| pump_dn_o | output | 1 | Down pump request |
| lock_o | output | 1 | Lock indicator with pump activity masked out |
| mon_o | output | 1 | Selected divided clock |

## Verification
The bench builds the block with `PULSE_W` = 4 and `LOCK_PERIODS` = 4, and drives a pulse limit of 3 cycles. With these values lock is gained within a few dozen cycles of in-phase inputs. A five-cycle phase offset then breaks lock clearly, so that acquisition, loss and re-acquisition all fit in short wave runs. The power-down scenario leaves one flag pending when the request arrives, which exposes the deferral. It then toggles both inputs while asleep and checks that nothing comes through.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef enum logic {
    PWR_RUN   = 1'b0,
    PWR_SLEEP = 1'b1
  } pwr_state_e;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lvl_i,
  output logic [LANES-1:0] rise_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic prev_q;
    logic prev_d;

    assign prev_d = lvl_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= prev_d;
    end

    assign rise_o[g] = lvl_i[g] & ~prev_q;
  end

endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise_i,
  input  logic vco_rise_i,
  input  logic pwr_on_i,
  output logic up_o,
  output logic dn_o,
  output logic asleep_o,
  output logic clear_o
);

  pwr_state_e st_q, st_d;
  logic       up_q, dn_q, up_d, dn_d;
  logic       idle, enter_sleep;

  assign idle        = ~up_q & ~dn_q;
  assign enter_sleep = (st_q == PWR_RUN) & ~pwr_on_i & idle;
  assign clear_o     = (st_q == PWR_SLEEP) | enter_sleep;

  // power state: next state
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PWR_RUN:   if (enter_sleep) st_d = PWR_SLEEP;
      PWR_SLEEP: if (pwr_on_i)    st_d = PWR_RUN;
      default:   st_d = PWR_RUN;
    endcase
  end

  // detector flags: next state
  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (clear_o) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else if (up_q & dn_q) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = up_q | ref_rise_i;
      dn_d = dn_q | vco_rise_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PWR_RUN;
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      st_q <= st_d;
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_o     = up_q;
  assign dn_o     = dn_q;
  assign asleep_o = (st_q == PWR_SLEEP);

  p_pair_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && dn_q) |=> (!up_q && !dn_q));

  p_sleep_from_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(!up_q && !dn_q));

  p_sleep_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && !pwr_on_i) |=> asleep_o);

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned PULSE_W      = 8,
  parameter int unsigned LOCK_PERIODS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active_i,
  input  logic               ref_rise_i,
  input  logic               clear_i,
  input  logic [PULSE_W-1:0] limit_i,
  output logic               lock_o
);

  localparam int unsigned        GOOD_W   = $clog2(LOCK_PERIODS + 1);
  localparam logic [GOOD_W-1:0]  GOOD_TOP = GOOD_W'(LOCK_PERIODS);
  localparam logic [GOOD_W-1:0]  GOOD_ARM = GOOD_W'(LOCK_PERIODS - 1);
  localparam logic [PULSE_W-1:0] W_MAX    = {PULSE_W{1'b1}};

  logic [PULSE_W-1:0] wcnt_q, wcnt_d;
  logic [GOOD_W-1:0]  good_q, good_d;
  logic               lock_q, lock_d;
  logic               wide;

  assign wide = active_i & (wcnt_q >= limit_i);

  // pulse width counter
  always_comb begin
    wcnt_d = '0;
    if (!clear_i && active_i) begin
      wcnt_d = (wcnt_q == W_MAX) ? wcnt_q : wcnt_q + 1'b1;
    end
  end

  // clean-period counter and lock state
  always_comb begin
    good_d = good_q;
    lock_d = lock_q;
    if (clear_i || wide) begin
      good_d = '0;
      lock_d = 1'b0;
    end else if (ref_rise_i) begin
      if (good_q != GOOD_TOP) good_d = good_q + 1'b1;
      if (good_q == GOOD_ARM) lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      good_q <= '0;
      lock_q <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      good_q <= good_d;
      lock_q <= lock_d;
    end
  end

  assign lock_o = lock_q & ~active_i;

  p_wide_drops_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !lock_q);

  p_lock_on_ref_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(ref_rise_i && !wide));

  p_clear_resets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (!lock_q && wcnt_q == '0 && good_q == '0));

endmodule

// File: rtl/pfd_gated_pd.sv
module pfd_gated_pd #(
  parameter int unsigned PULSE_W      = 8,
  parameter int unsigned LOCK_PERIODS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_in,
  input  logic               vco_in,
  input  logic               pol_normal_i,
  input  logic               pwr_on_i,
  input  logic [PULSE_W-1:0] pulse_limit_i,
  input  logic               mon_sel_i,
  output logic               pump_up_o,
  output logic               pump_dn_o,
  output logic               lock_o,
  output logic               mon_o
);

  localparam int unsigned LANES = 2;
  localparam int unsigned L_REF = 0;
  localparam int unsigned L_VCO = 1;

  logic [LANES-1:0] lvl, rise;
  logic             up_f, dn_f, asleep, clear;
  logic             active;

  assign lvl[L_REF] = ref_in;
  assign lvl[L_VCO] = vco_in;

  pfd_edge_det #(.LANES(LANES)) i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  pfd_flag_core i_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_rise_i (rise[L_REF]),
    .vco_rise_i (rise[L_VCO]),
    .pwr_on_i   (pwr_on_i),
    .up_o       (up_f),
    .dn_o       (dn_f),
    .asleep_o   (asleep),
    .clear_o    (clear)
  );

  assign active = up_f | dn_f;

  pfd_lock_mon #(
    .PULSE_W      (PULSE_W),
    .LOCK_PERIODS (LOCK_PERIODS)
  ) i_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .ref_rise_i (rise[L_REF]),
    .clear_i    (clear),
    .limit_i    (pulse_limit_i),
    .lock_o     (lock_o)
  );

  always_comb begin
    if (pol_normal_i) begin
      pump_up_o = up_f;
      pump_dn_o = dn_f;
    end else begin
      pump_up_o = dn_f;
      pump_dn_o = up_f;
    end
  end

  assign mon_o = mon_sel_i ? vco_in : ref_in;

  p_sleep_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (!pump_up_o && !pump_dn_o && !lock_o));

  p_pump_masks_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_up_o || pump_dn_o) |-> !lock_o);

endmodule

// File: tb/test_pfd_gated_pd.sv
module test_pfd_gated_pd;

  localparam int    PW     = 4;
  localparam int    NLOCK  = 4;
  localparam time   T_CLK  = 10ns;
  localparam int    W_MAX  = (1 << PW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_in = 1'b0, vco_in = 1'b0;
  logic          pol_normal_i = 1'b1, pwr_on_i = 1'b1, mon_sel_i = 1'b0;
  logic [PW-1:0] pulse_limit_i = PW'(3);
  logic          pump_up_o, pump_dn_o, lock_o, mon_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_tag  = "R1";
  bit    done     = 1'b0;

  always #(T_CLK/2) clk = ~clk;

  pfd_gated_pd #(.PULSE_W(PW), .LOCK_PERIODS(NLOCK)) i_pfd_gated_pd (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
    .pol_normal_i(pol_normal_i), .pwr_on_i(pwr_on_i),
    .pulse_limit_i(pulse_limit_i), .mon_sel_i(mon_sel_i),
    .pump_up_o(pump_up_o), .pump_dn_o(pump_dn_o),
    .lock_o(lock_o), .mon_o(mon_o)
  );

  // behavioural reference model
  bit m_rp = 0, m_vp = 0, m_up = 0, m_dn = 0, m_sl = 0, m_lock = 0;
  int m_w = 0, m_good = 0;

  always @(posedge clk) begin
    bit rr, vr, act, wide, enter;
    if (!rst_n) begin
      m_rp = 0; m_vp = 0; m_up = 0; m_dn = 0; m_sl = 0; m_lock = 0;
      m_w = 0; m_good = 0;
    end else begin
      rr    = ref_in && !m_rp;
      vr    = vco_in && !m_vp;
      act   = m_up || m_dn;
      wide  = act && (m_w >= int'(pulse_limit_i));
      enter = !m_sl && !pwr_on_i && !act;
      if (m_sl || enter) begin
        m_up = 0; m_dn = 0; m_w = 0; m_good = 0; m_lock = 0;
        if (m_sl && pwr_on_i) m_sl = 0;
        if (enter) m_sl = 1;
      end else begin
        if (m_up && m_dn) begin
          m_up = 0; m_dn = 0;
        end else begin
          m_up = m_up || rr;
          m_dn = m_dn || vr;
        end
        m_w = act ? ((m_w < W_MAX) ? m_w + 1 : m_w) : 0;
        if (wide) begin
          m_good = 0; m_lock = 0;
        end else if (rr) begin
          if (m_good < NLOCK) m_good = m_good + 1;
          if (m_good == NLOCK) m_lock = 1;
        end
      end
      m_rp = ref_in;
      m_vp = vco_in;
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    int e_up, e_dn, e_lk, e_mon;
    if (rst_n && !done) begin
      e_up  = pol_normal_i ? m_up : m_dn;
      e_dn  = pol_normal_i ? m_dn : m_up;
      e_lk  = m_lock && !(m_up || m_dn);
      e_mon = mon_sel_i ? vco_in : ref_in;
      check({pump_up_o, pump_dn_o, lock_o, mon_o} == 4'({e_up[0], e_dn[0], e_lk[0], e_mon[0]}),
            cur_tag, "outputs {up,dn,lock,mon}",
            int'({pump_up_o, pump_dn_o, lock_o, mon_o}),
            int'({e_up[0], e_dn[0], e_lk[0], e_mon[0]}));
    end
  end

  task automatic tick(bit r, bit v);
    @(posedge clk);
    #1;
    ref_in = r;
    vco_in = v;
  endtask

  task automatic sync_idle();
    tick(0, 0); tick(0, 0);
    tick(1, 1); tick(1, 1); tick(1, 1);
    tick(0, 0); tick(0, 0);
  endtask

  task automatic waves(int n, int rp, int vp, int voff);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      ref_in = ((k % rp) < rp / 2);
      vco_in = (((k + voff) % vp) < vp / 2);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!pump_up_o && !pump_dn_o && !lock_o, "R1", "outputs in reset",
          int'({pump_up_o, pump_dn_o, lock_o}), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    check(!pump_up_o && !pump_dn_o && !lock_o, "R1", "outputs after reset",
          int'({pump_up_o, pump_dn_o, lock_o}), 0);

    // R2 / R3: single requests and pair clearing
    cur_tag = "R2";
    sync_idle();
    tick(1, 0); tick(1, 0);
    @(negedge clk);
    check(pump_up_o && !pump_dn_o, "R2", "ref edge -> up only",
          int'({pump_up_o, pump_dn_o}), 2);
    tick(1, 0); tick(1, 0);
    @(negedge clk);
    check(pump_up_o, "R2", "up held until vco edge", int'(pump_up_o), 1);
    cur_tag = "R3";
    tick(1, 1); tick(1, 1);
    @(negedge clk);
    check(pump_up_o && pump_dn_o, "R3", "both set after vco edge",
          int'({pump_up_o, pump_dn_o}), 3);
    tick(1, 1);
    @(negedge clk);
    check(!pump_up_o && !pump_dn_o, "R3", "both clear next cycle",
          int'({pump_up_o, pump_dn_o}), 0);

    // R7: lock with in-phase inputs
    cur_tag = "R7";
    waves(160, 16, 16, 0);
    @(negedge clk);
    check(lock_o, "R7", "lock after clean periods", int'(lock_o), 1);

    // R9: lock masked during a pump pulse
    cur_tag = "R9";
    tick(0, 0); tick(0, 0); tick(1, 1); tick(1, 1);
    @(negedge clk);
    check(!lock_o && pump_up_o && pump_dn_o, "R9", "lock masked by pulse",
          int'({pump_up_o, pump_dn_o, lock_o}), 6);
    tick(1, 1);
    @(negedge clk);
    check(lock_o, "R9", "lock back after pulse", int'(lock_o), 1);

    // R5: deferred power-down
    cur_tag = "R5";
    sync_idle();
    tick(1, 0); tick(1, 0);
    pwr_on_i = 1'b0;
    tick(0, 0); tick(0, 0); tick(1, 0); tick(1, 0);
    @(negedge clk);
    check(pump_up_o, "R5", "pending up survives request", int'(pump_up_o), 1);
    tick(1, 1); tick(1, 1); tick(1, 1);
    tick(0, 0); tick(0, 0); tick(0, 0);
    for (int k = 0; k < 6; k++) begin
      tick(k[0], !k[0]);
      @(negedge clk);
      check(!pump_up_o && !pump_dn_o && !lock_o, "R5", "asleep outputs idle",
            int'({pump_up_o, pump_dn_o, lock_o}), 0);
    end

    // R6: wake-up
    cur_tag = "R6";
    tick(0, 0);
    pwr_on_i = 1'b1;
    tick(0, 0); tick(0, 0);
    @(negedge clk);
    check(!lock_o && !pump_up_o && !pump_dn_o, "R6", "clear after wake",
          int'({pump_up_o, pump_dn_o, lock_o}), 0);
    tick(1, 0); tick(1, 0);
    @(negedge clk);
    check(pump_up_o && !pump_dn_o, "R6", "first edge after wake",
          int'({pump_up_o, pump_dn_o}), 2);
    tick(1, 1); tick(1, 1); tick(1, 1);

    // R4: swapped polarity
    cur_tag = "R4";
    sync_idle();
    pol_normal_i = 1'b0;
    tick(1, 0); tick(1, 0);
    @(negedge clk);
    check(!pump_up_o && pump_dn_o, "R4", "ref request on dn",
          int'({pump_up_o, pump_dn_o}), 1);
    tick(1, 1); tick(1, 1); tick(1, 1);
    sync_idle();
    tick(0, 1); tick(0, 1);
    @(negedge clk);
    check(pump_up_o && !pump_dn_o, "R4", "vco request on up",
          int'({pump_up_o, pump_dn_o}), 2);
    tick(1, 1); tick(1, 1); tick(1, 1);
    pol_normal_i = 1'b1;

    // R7 again, then R8: a wide pulse breaks lock
    cur_tag = "R7";
    waves(160, 16, 16, 0);
    @(negedge clk);
    check(lock_o, "R7", "relock after wake", int'(lock_o), 1);
    cur_tag = "R8";
    waves(160, 16, 16, 5);
    @(negedge clk);
    check(!lock_o, "R8", "wide pulses drop lock", int'(lock_o), 0);

    // R10: monitor select
    cur_tag = "R10";
    tick(1, 0);
    @(negedge clk);
    check(mon_o == 1'b1, "R10", "mon shows ref", int'(mon_o), 1);
    #1 mon_sel_i = 1'b1;
    #1;
    check(mon_o == 1'b0, "R10", "mon shows vco", int'(mon_o), 0);
    tick(0, 1);
    @(negedge clk);
    check(mon_o == 1'b1, "R10", "mon follows vco", int'(mon_o), 1);

    finish_run();
  end

endmodule